// File: doc/BRIEF.md
# Synchronous Burst SRAM Read Return Stage

This block is the read data return path of a small synchronous burst SRAM. Every operation is started by a command. A read or write command loads a base address. Later no-op cycles with the advance input high step a 2-bit burst counter that wraps inside an aligned group of four words. The counter steps in linear or interleaved order.

A static mode input picks the read path:
- **Pipelined mode:** the word read from the array passes through a rising-edge output register, so the first word of a burst reaches the bus one cycle later.
- **Flow-through mode:** the word skips that register.

The per-cycle "read live" flag travels down the same stages as the data. A deselect therefore takes as many edges to turn the bus off as a read takes to turn it on, which gives dual-cycle-deselect timing in pipelined mode. An asynchronous output enable gates a drive-enable output that sits next to the data bus.

Control is a three-state machine:
- **IDLE:** deselected. This is the reset state.
- **READ:** a read burst is open.
- **WRITE:** a write burst is open.

Transitions:
- A read command moves to READ from any state.
- A write command moves to WRITE from any state.
- A deselect command returns to IDLE from any state.
- A no-op keeps the current state. In READ, a no-op with advance low re-reads the current word, and a no-op with advance high moves to the next burst word. In WRITE, a no-op writes only when advance is high. In IDLE, the advance input is ignored.

Top module: `sram_rd_stage`

## Requirements
- R1: In flow-through mode (`pipe_en`=0), a read command (`cmd`=2'b01) sampled at edge k drives word `addr` on the bus right after edge k.
- R2: In pipelined mode (`pipe_en`=1), the same read drives its word right after edge k+1. Reads are 3-1-1-1 against 2-1-1-1 in flow-through mode.
- R3: In linear order (`lin_burst`=1), each no-op with `adv`=1 in a burst moves to the next word. Address bits [1:0] go to (base+n) mod 4 and the upper bits are kept.
- R4: In interleaved order (`lin_burst`=0), the nth burst word has bits [1:0] equal to base[1:0] XOR n.
- R5: A no-op with `adv`=0 during a read burst returns the same word again.
- R6: After a deselect (`cmd`=2'b11) at edge k in pipelined mode, the bus stays driven after edge k and stops after edge k+1. In flow-through mode it stops after edge k.
- R7: `bus_oe` is low whenever `out_en` is low. It follows `out_en` without waiting for a clock edge.
- R8: A write (`cmd`=2'b10) updates only the bytes whose `wr_be` bit is set (bit i is bits 8i+7..8i). With `wr_all`=1, every byte is updated whatever `wr_be` holds.
- R9: The bus is never driven in the cycle that a write's data would occupy, in either mode.
- R10: While `rst_n` is low, `bus_oe` is low, the state is IDLE and the pipeline holds no read.
- R11: A write burst writes the start address, then one further burst word for each no-op with `adv`=1, in the selected order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_en | input | 1 | Static mode: 1 selects the registered output path, 0 selects the bypass |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 deselect |
| addr | input | AW | Start address, taken on read and write commands |
| adv | input | 1 | Advance the burst on a no-op |
| wr_data | input | DW | Write data for the current write cycle |
| wr_be | input | DW/8 | Byte write enables |
| wr_all | input | 1 | Write every byte regardless of `wr_be` |
| out_en | input | 1 | Asynchronous output enable |
| bus_dq | output | DW | Read data bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The inputs change on the falling edge. Each result is sampled at the next falling edge, half a cycle after the rising edge that acts on it. A flow-through result is due one sample after its command and a pipelined result two samples after it. The stimulus table therefore lists, for each cycle, the value the bus must show at the sample after that cycle's edge, taking mode and burst order into account. The output-enable and reset checks are made between clock edges, after a 1 ns delay, so that they show that no edge is needed.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_DESEL = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } st_e;

    // Low address bits of the nth word of a four-word burst.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] n,
                                            input logic       lin);
        return lin ? (base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
    import sram_rd_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          lin,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam int CW = 2;

    logic [AW-1:0] base_q, base_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        base_n = base_q;
        cnt_n  = cnt_q;
        if (load) begin
            base_n = load_addr;
            cnt_n  = '0;
        end else if (step) begin
            cnt_n  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
        end
    end

    assign cur_addr = {base_q[AW-1:CW], burst_lo(base_q[CW-1:0], cnt_q, lin)};
    assign nxt_addr = {base_n[AW-1:CW], burst_lo(base_n[CW-1:0], cnt_n, lin)};

    // R3/R4: stepping never leaves the aligned four-word group
    p_burst_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr[AW-1:CW] == $past(cur_addr[AW-1:CW])))
        else $error("burst left its group");

endmodule

// File: rtl/sram_word_array.sv
module sram_word_array #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] wmask,
    input  logic [AW-1:0]   raddr,
    output logic [DW-1:0]   rdata
);
    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) lane_mem[waddr] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = lane_mem[raddr];
    end

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_en,
    input  logic          s1_live,
    input  logic [DW-1:0] s1_word,
    input  logic          out_en,
    output logic          drive_v,
    output logic [DW-1:0] bus_dq,
    output logic          bus_oe
);
    logic          s2_live;
    logic [DW-1:0] s2_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_live <= 1'b0;
            s2_word <= '0;
        end else begin
            s2_live <= s1_live;
            s2_word <= s1_word;
        end
    end

    always_comb begin
        drive_v = pipe_en ? s2_live : s1_live;
        bus_dq  = pipe_en ? s2_word : s1_word;
        bus_oe  = out_en & drive_v;
    end

    // R7: output enable low keeps the bus released
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !bus_oe)
        else $error("bus driven with output enable low");

    // R2: in pipelined mode a live first stage shows up one edge later
    p_pipe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && s1_live) |=> drive_v)
        else $error("pipelined stage lost a read");

endmodule

// File: rtl/sram_rd_stage.sv
module sram_rd_stage
    import sram_rd_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pipe_en,
    input  logic            lin_burst,
    input  logic [1:0]      cmd,
    input  logic [AW-1:0]   addr,
    input  logic            adv,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW/8-1:0] wr_be,
    input  logic            wr_all,
    input  logic            out_en,
    output logic [DW-1:0]   bus_dq,
    output logic            bus_oe
);
    localparam int NB = DW / 8;

    cmd_e          cmd_c;
    st_e           state_q, state_n;
    logic          ld, stp, we;
    logic [NB-1:0] wmask;
    logic [AW-1:0] cur_addr, nxt_addr;
    logic [DW-1:0] rd_word;
    logic          s1_live, drive_v;

    assign cmd_c = cmd_e'(cmd);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (cmd_c)
            CMD_NOP:   state_n = state_q;
            CMD_READ:  state_n = ST_READ;
            CMD_WRITE: state_n = ST_WRITE;
            CMD_DESEL: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // output decode
    always_comb begin
        ld      = (cmd_c == CMD_READ) || (cmd_c == CMD_WRITE);
        stp     = (cmd_c == CMD_NOP) && adv && (state_q != ST_IDLE);
        we      = (cmd_c == CMD_WRITE) ||
                  ((cmd_c == CMD_NOP) && adv && (state_q == ST_WRITE));
        wmask   = wr_all ? {NB{1'b1}} : wr_be;
        s1_live = (state_q == ST_READ);
    end

    sram_burst_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .step      (stp),
        .lin       (lin_burst),
        .load_addr (addr),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    sram_word_array #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (nxt_addr),
        .wdata (wr_data),
        .wmask (wmask),
        .raddr (cur_addr),
        .rdata (rd_word)
    );

    sram_out_pipe #(.DW(DW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pipe_en (pipe_en),
        .s1_live (s1_live),
        .s1_word (rd_word),
        .out_en  (out_en),
        .drive_v (drive_v),
        .bus_dq  (bus_dq),
        .bus_oe  (bus_oe)
    );

    // R1: flow-through read is live right after its command edge
    p_flow_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && cmd_c == CMD_READ) |=> drive_v)
        else $error("flow-through read late");

    // R2: pipelined read is live one edge later
    p_pipe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && cmd_c == CMD_READ) |-> ##2 drive_v)
        else $error("pipelined read late");

    // R6: pipelined deselect holds the bus for one more cycle
    p_desel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && cmd_c == CMD_DESEL && state_q == ST_READ) |=> drive_v ##1 !drive_v)
        else $error("deselect timing wrong");

    // R9: no drive in the slot of a write
    p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && cmd_c == CMD_WRITE) |=> !drive_v)
        else $error("bus driven during write");

endmodule

// File: tb/sim_sram_rd_stage.sv
module sim_sram_rd_stage;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int NV = 27;

    typedef struct packed {
        logic       pipe;
        logic       lin;
        logic [1:0] cmd;
        logic [5:0] addr;
        logic       adv;
        logic       oe;
        logic       ev;
        logic [5:0] ea;
    } vec_t;

    // per cycle: inputs, then bus state expected at the sample after that edge
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,2'b01,6'd5, 1'b0,1'b1,1'b1,6'd5 },  // R1 flow read
        '{1'b0,1'b1,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd6 },  // R3
        '{1'b0,1'b1,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd7 },  // R3
        '{1'b0,1'b1,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd4 },  // R3 wrap
        '{1'b0,1'b1,2'b00,6'd0, 1'b0,1'b1,1'b1,6'd4 },  // R5 hold
        '{1'b0,1'b1,2'b11,6'd0, 1'b0,1'b1,1'b0,6'd0 },  // R6 flow off
        '{1'b0,1'b0,2'b01,6'd9, 1'b0,1'b1,1'b1,6'd9 },  // R4
        '{1'b0,1'b0,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd8 },  // R4
        '{1'b0,1'b0,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd11},  // R4
        '{1'b0,1'b0,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd10},  // R4
        '{1'b0,1'b0,2'b11,6'd0, 1'b0,1'b1,1'b0,6'd0 },  // R6
        '{1'b1,1'b1,2'b01,6'd2, 1'b0,1'b1,1'b0,6'd0 },  // R2 not yet
        '{1'b1,1'b1,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd2 },  // R2
        '{1'b1,1'b1,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd3 },  // R3
        '{1'b1,1'b1,2'b11,6'd0, 1'b0,1'b1,1'b1,6'd0 },  // R6 still driven
        '{1'b1,1'b1,2'b00,6'd0, 1'b0,1'b1,1'b0,6'd0 },  // R6 off
        '{1'b1,1'b0,2'b01,6'd14,1'b0,1'b1,1'b0,6'd0 },  // R2
        '{1'b1,1'b0,2'b00,6'd0, 1'b1,1'b0,1'b0,6'd0 },  // R7 gated
        '{1'b1,1'b0,2'b00,6'd0, 1'b1,1'b1,1'b1,6'd15},  // R4
        '{1'b1,1'b0,2'b11,6'd0, 1'b0,1'b1,1'b1,6'd12},  // R6
        '{1'b1,1'b0,2'b00,6'd0, 1'b0,1'b1,1'b0,6'd0 },  // R6
        '{1'b1,1'b1,2'b01,6'd20,1'b0,1'b1,1'b0,6'd0 },  // R2
        '{1'b1,1'b1,2'b10,6'd60,1'b0,1'b1,1'b1,6'd20},  // R2
        '{1'b1,1'b1,2'b00,6'd0, 1'b0,1'b1,1'b0,6'd0 },  // R9 pipe
        '{1'b1,1'b1,2'b11,6'd0, 1'b0,1'b1,1'b0,6'd0 },
        '{1'b0,1'b1,2'b10,6'd61,1'b0,1'b1,1'b0,6'd0 },  // R9 flow
        '{1'b0,1'b1,2'b00,6'd0, 1'b0,1'b1,1'b0,6'd0 }   // R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_en = 1'b0;
    logic          lin_burst = 1'b1;
    logic [1:0]    cmd = 2'b00;
    logic [AW-1:0] addr = '0;
    logic          adv = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] wr_be = '1;
    logic          wr_all = 1'b0;
    logic          out_en = 1'b1;
    logic [DW-1:0] bus_dq;
    logic          bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_rd_stage #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .lin_burst(lin_burst),
        .cmd(cmd), .addr(addr), .adv(adv), .wr_data(wr_data), .wr_be(wr_be),
        .wr_all(wr_all), .out_en(out_en), .bus_dq(bus_dq), .bus_oe(bus_oe)
    );

    function automatic logic [31:0] pat(input logic [5:0] a);
        return {8'h5A, {2'b00, a}, ~{2'b00, a}, {2'b00, a} ^ 8'h3C};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [5:0] a, input logic ad,
                        input logic [31:0] d, input logic [3:0] be, input logic all);
        cmd = c; addr = a; adv = ad; wr_data = d; wr_be = be; wr_all = all;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset oe", {31'd0, bus_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // fill through linear write bursts (R11)
        for (int b = 0; b < 64; b += 4) begin
            step(2'b10, 6'(b), 1'b0, pat(6'(b)), 4'hF, 1'b0);
            for (int k = 1; k < 4; k++)
                step(2'b00, 6'd0, 1'b1, pat(6'(b + k)), 4'hF, 1'b0);
        end
        step(2'b11, 6'd0, 1'b0, 32'd0, 4'hF, 1'b0);

        // R11 readback of a burst-written group
        step(2'b01, 6'd37, 1'b0, 32'd0, 4'hF, 1'b0);
        chk("R11 burst write word", bus_dq, pat(6'd37));
        step(2'b11, 6'd0, 1'b0, 32'd0, 4'hF, 1'b0);

        for (int i = 0; i < NV; i++) begin
            pipe_en = TBL[i].pipe;
            lin_burst = TBL[i].lin;
            out_en = TBL[i].oe;
            step(TBL[i].cmd, TBL[i].addr, TBL[i].adv, pat(TBL[i].addr), 4'hF, 1'b0);
            chk($sformatf("R1-6/R9 vec%0d oe", i), {31'd0, bus_oe}, {31'd0, TBL[i].ev});
            if (TBL[i].ev)
                chk($sformatf("vec%0d data", i), bus_dq, pat(TBL[i].ea));
        end
        out_en = 1'b1;
        pipe_en = 1'b0;
        lin_burst = 1'b1;
        step(2'b11, 6'd0, 1'b0, 32'd0, 4'hF, 1'b0);

        // R8 byte lane write
        step(2'b10, 6'd30, 1'b0, 32'hFFFF_FFFF, 4'b0010, 1'b0);
        step(2'b01, 6'd30, 1'b0, 32'd0, 4'hF, 1'b0);
        chk("R8 byte lane", bus_dq, (pat(6'd30) & 32'hFFFF_00FF) | 32'h0000_FF00);
        // R8 empty mask writes nothing
        step(2'b10, 6'd32, 1'b0, 32'h0, 4'b0000, 1'b0);
        step(2'b01, 6'd32, 1'b0, 32'd0, 4'hF, 1'b0);
        chk("R8 empty mask", bus_dq, pat(6'd32));
        // R8 global write overrides mask
        step(2'b10, 6'd31, 1'b0, 32'h1234_5678, 4'b0000, 1'b1);
        step(2'b01, 6'd31, 1'b0, 32'd0, 4'hF, 1'b0);
        chk("R8 global write", bus_dq, 32'h1234_5678);

        // R7 asynchronous output enable, between edges
        out_en = 1'b0;
        #1;
        chk("R7 async off", {31'd0, bus_oe}, 32'd0);
        out_en = 1'b1;
        #1;
        chk("R7 async on", {31'd0, bus_oe}, 32'd1);

        // R10 reset during an open read
        rst_n = 1'b0;
        #1;
        chk("R10 reset mid read", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 6'd0, 1'b1, 32'd0, 4'hF, 1'b0);
        chk("R10 idle after reset", {31'd0, bus_oe}, 32'd0);

        finish_run();
    end

endmodule